// File: doc/BRIEF.md
# Sixteen-Bit I/O Port with Pin Interrupts

This block is a 16-pin general-purpose I/O port controlled through a simple word-addressed register interface. It holds the value each pin drives, a per-pin drive enable, and a per-pin interrupt enable, trigger type and trigger polarity. Software never writes these control words directly. Each one has a set address and a clear address: a write to the set address turns on the bits that are 1 in the written data, and a write to the clear address turns them off. Reading either address returns the current value. Output data is written through byte windows. The lower eight address bits of a window address act as a bit mask, so a single write can change any chosen subset of one byte and leave the rest of the port alone.

The pins are always sampled. The samples pass through a two-stage synchronizer, and the input register shows the synchronized levels. Each pin's trigger type and polarity pick one of four conditions: low level, high level, falling edge or rising edge. A pin that meets its condition latches a pending bit. Software reads the pending bits and clears them by writing 1s to the status address. One combined interrupt line is raised while any pin is both enabled and pending.

An open-drain pin is emulated by leaving its data bit at 0 and switching its drive enable. Enable on pulls the pin low. Enable off leaves the pin floating, so an external pull-up can raise it.

Top module: `pio_port`

## Requirements
- R1: After reset, the drive enables, output data, interrupt enables, trigger types, polarities and the interrupt line are all 0.
- R2: Each control word has two addresses: set (enable 0x02, int-enable 0x04, type 0x06, polarity 0x08) and clear (0x03, 0x05, 0x07, 0x09). A write ORs in the 1 bits at the set address and removes them at the clear address. Bits written as 0 keep their value. Reading either address returns the current word.
- R3: Address bits [9:8] = 01 select the low-byte window and = 10 select the high-byte window. Address bits [7:0] form a mask: only masked bits of the chosen byte take the written data bits, and all other output bits keep their value. The output data word can be read at 0x01.
- R4: `pin_out` equals the output data word and `pin_oe` equals the drive-enable word, bit for bit. An open-drain high is a 0 data bit with its enable cleared.
- R5: The input word at address 0x00 shows `pin_in` two clock edges after the pins change.
- R6: Trigger {type,polarity} = 00 (low level) keeps a pin's pending bit set while its synchronized level is 0.
- R7: Trigger 01 (high level) keeps a pin's pending bit set while its synchronized level is 1.
- R8: Trigger 10 (falling edge) sets the pending bit once per 1→0 change. A rising change does not set it.
- R9: Trigger 11 (rising edge) sets the pending bit once per 0→1 change. A falling change does not set it.
- R10: Pending bits are read at 0x0A. Writing a 1 to a bit there clears it on that edge. A level condition that still holds sets the bit again on the next edge.
- R11: `irq` is 1 exactly when some pin has both its interrupt enable and its pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 10 | Word address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` (combinational) |
| pin_in | input | 16 | Pin levels, asynchronous |
| pin_out | output | 16 | Value driven on each pin |
| pin_oe | output | 16 | Per-pin drive enable |
| irq | output | 1 | Combined interrupt |

## Verification
The set and clear aliases are tried with overlapping, disjoint and all-zero data. This separates OR/AND-NOT behaviour from a plain overwrite. The byte windows are tried with sparse masks in both bytes, which exposes a swapped lane or an ignored mask. Each of the four trigger modes is driven with both a pin transition that should fire and one that should not. For the edge modes, the pending bit is checked again after it is cleared, to tell a one-shot edge apart from a level. For the level mode, the bit is read on the clearing edge and on the edge after it, which shows the clear taking effect and the bit setting again.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
// Shared address map and trigger encoding for the I/O port.
package pio_pkg;
    localparam int unsigned A_DIN      = 0;
    localparam int unsigned A_DOUT     = 1;
    localparam int unsigned A_OE_SET   = 2;
    localparam int unsigned A_OE_CLR   = 3;
    localparam int unsigned A_IE_SET   = 4;
    localparam int unsigned A_IE_CLR   = 5;
    localparam int unsigned A_TYP_SET  = 6;
    localparam int unsigned A_TYP_CLR  = 7;
    localparam int unsigned A_POL_SET  = 8;
    localparam int unsigned A_POL_CLR  = 9;
    localparam int unsigned A_PEND     = 10;

    // {type, polarity}
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_RISE = 2'b11
    } trig_e;
endpackage

// File: rtl/pio_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer plus a history stage for edge detection.
// Assumes pin_in is asynchronous; cur is the settled sample and prev
// the sample one cycle older.
module pio_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);
    logic [WIDTH-1:0] meta_q, cur_q, prev_q;

    // Shift pin samples through the three stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur  = cur_q;
    assign prev = prev_q;
endmodule

// File: rtl/pio_trig.sv
`timescale 1ns/1ps
// Per-pin trigger condition: level or edge, picked by type and polarity.
// Purely combinational; assumes cur/prev come from the synchronizer.
module pio_trig #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] prev,
    input  logic [WIDTH-1:0] typ,
    input  logic [WIDTH-1:0] pol,
    output logic [WIDTH-1:0] hit
);
    import pio_pkg::*;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        trig_e mode;
        assign mode = trig_e'({typ[i], pol[i]});
        // Evaluate this pin's condition for its selected mode.
        always_comb begin
            unique case (mode)
                TRIG_LOW:  hit[i] = ~cur[i];
                TRIG_HIGH: hit[i] =  cur[i];
                TRIG_FALL: hit[i] = ~cur[i] &  prev[i];
                TRIG_RISE: hit[i] =  cur[i] & ~prev[i];
                default:   hit[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pio_regs.sv
`timescale 1ns/1ps
// Register file: set/clear control words, masked output byte windows,
// pending status with write-1-to-clear, and read mux.
// Assumes WIDTH is a multiple of 8 and ADDR_W >= 9 + clog2 of lanes.
module pio_regs #(
    parameter int WIDTH  = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [WIDTH-1:0]  din,
    input  logic [WIDTH-1:0]  hit,
    output logic [WIDTH-1:0]  rd_data,
    output logic [WIDTH-1:0]  dout,
    output logic [WIDTH-1:0]  oe,
    output logic [WIDTH-1:0]  ie,
    output logic [WIDTH-1:0]  typ,
    output logic [WIDTH-1:0]  pol,
    output logic [WIDTH-1:0]  pend
);
    import pio_pkg::*;

    localparam int LANES = WIDTH / 8;
    localparam int PAGE_W = ADDR_W - 8;

    logic [WIDTH-1:0] dout_nxt;
    logic [PAGE_W-1:0] page;
    logic             in_regs;

    assign page    = addr[ADDR_W-1:8];
    assign in_regs = (page == '0);

    function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned r);
        return a == ADDR_W'(r);
    endfunction

    // Merge masked window writes into the next output word.
    always_comb begin
        dout_nxt = dout;
        for (int l = 0; l < LANES; l++) begin
            if (wr_en && page == PAGE_W'(l + 1)) begin
                for (int b = 0; b < 8; b++) begin
                    if (addr[b]) dout_nxt[l*8+b] = wr_data[l*8+b];
                end
            end
        end
    end

    // Update control words, output data and pending status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            oe   <= '0;
            ie   <= '0;
            typ  <= '0;
            pol  <= '0;
            pend <= '0;
        end else begin
            dout <= dout_nxt;
            if (wr_en && at(addr, A_OE_SET))  oe  <= oe  |  wr_data;
            if (wr_en && at(addr, A_OE_CLR))  oe  <= oe  & ~wr_data;
            if (wr_en && at(addr, A_IE_SET))  ie  <= ie  |  wr_data;
            if (wr_en && at(addr, A_IE_CLR))  ie  <= ie  & ~wr_data;
            if (wr_en && at(addr, A_TYP_SET)) typ <= typ |  wr_data;
            if (wr_en && at(addr, A_TYP_CLR)) typ <= typ & ~wr_data;
            if (wr_en && at(addr, A_POL_SET)) pol <= pol |  wr_data;
            if (wr_en && at(addr, A_POL_CLR)) pol <= pol & ~wr_data;
            pend <= (pend | hit) & ~((wr_en && at(addr, A_PEND)) ? wr_data : '0);
        end
    end

    // Select read data for the current address.
    always_comb begin
        rd_data = '0;
        if (!in_regs) begin
            rd_data = dout;
        end else begin
            unique case (addr[7:0])
                8'(A_DIN):                  rd_data = din;
                8'(A_DOUT):                 rd_data = dout;
                8'(A_OE_SET), 8'(A_OE_CLR): rd_data = oe;
                8'(A_IE_SET), 8'(A_IE_CLR): rd_data = ie;
                8'(A_TYP_SET),8'(A_TYP_CLR):rd_data = typ;
                8'(A_POL_SET),8'(A_POL_CLR):rd_data = pol;
                8'(A_PEND):                 rd_data = pend;
                default:                    rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/pio_port.sv
`timescale 1ns/1ps
// I/O port top: synchronizer, trigger logic and register file, with a
// combined interrupt. Assumes a synchronous register bus (one write per
// cycle, combinational read).
module pio_port #(
    parameter int WIDTH  = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  rd_data,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              irq
);
    logic [WIDTH-1:0] cur_s, prev_s, hit_s;
    logic [WIDTH-1:0] dout_q, oe_q, ie_q, typ_q, pol_q, pend_q;

    pio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cur(cur_s), .prev(prev_s)
    );

    pio_trig #(.WIDTH(WIDTH)) u_trig (
        .cur(cur_s), .prev(prev_s), .typ(typ_q), .pol(pol_q), .hit(hit_s)
    );

    pio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .din(cur_s), .hit(hit_s), .rd_data(rd_data),
        .dout(dout_q), .oe(oe_q), .ie(ie_q), .typ(typ_q), .pol(pol_q),
        .pend(pend_q)
    );

    assign pin_out = dout_q;
    assign pin_oe  = oe_q;
    // Raise the interrupt when any enabled pin is pending.
    assign irq     = |(pend_q & ie_q);
endmodule

// File: rtl/pio_port_chk.sv
`timescale 1ns/1ps
// Protocol checks for pio_port, bound onto the top module.
module pio_port_chk #(
    parameter int WIDTH  = 16,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [WIDTH-1:0]  wr_data,
    input logic [WIDTH-1:0]  oe,
    input logic [WIDTH-1:0]  ie,
    input logic [WIDTH-1:0]  pend,
    input logic [WIDTH-1:0]  dout,
    input logic [WIDTH-1:0]  pin_oe,
    input logic              irq
);
    import pio_pkg::*;

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (oe == '0 && dout == '0 && ie == '0 && !irq)); // R1

    AST_OE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(A_OE_SET)) |=> ((oe & $past(wr_data)) == $past(wr_data))); // R2

    AST_OE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(A_OE_CLR)) |=> ((oe & $past(wr_data)) == '0)); // R2

    AST_LOW_WIN_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[ADDR_W-1:8] == 1) |=> (dout[WIDTH-1:8] == $past(dout[WIDTH-1:8]))); // R3

    AST_PIN_OE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> $stable(pin_oe)); // R4

    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(A_PEND)) |=> ((pend & $past(wr_data)) == '0)); // R10

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie != '0 && pend != '0)); // R11
endmodule

bind pio_port pio_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .oe(oe_q), .ie(ie_q), .pend(pend_q), .dout(dout_q), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/sim_pio_port.sv
`timescale 1ns/1ps
module sim_pio_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;
    logic        irq;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pio_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [9:0] a, input logic [15:0] exp);
        addr = a; #0.5;
        chk(tag, rd_data, exp);
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        rd("R1 oe", 10'h002, 16'h0);
        rd("R1 dout", 10'h001, 16'h0);
        rd("R1 ie", 10'h004, 16'h0);
        rd("R1 type", 10'h006, 16'h0);
        rd("R1 pol", 10'h008, 16'h0);
        chk("R1 pin_oe", pin_oe, 16'h0);
        chk("R1 irq", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_setclr();
        wr(10'h002, 16'h00F0);
        rd("R2 oe set", 10'h002, 16'h00F0);
        rd("R2 oe via clr addr", 10'h003, 16'h00F0);
        wr(10'h003, 16'h0030);
        rd("R2 oe clr", 10'h002, 16'h00C0);
        wr(10'h002, 16'h0000);
        rd("R2 zero set no effect", 10'h002, 16'h00C0);
        chk("R4 pin_oe", pin_oe, 16'h00C0);
        wr(10'h006, 16'h1234);
        wr(10'h007, 16'h0204);
        rd("R2 type", 10'h007, 16'h1030);
        wr(10'h007, 16'hFFFF);
        rd("R2 type cleared", 10'h006, 16'h0);
        wr(10'h003, 16'hFFFF);
    endtask

    task automatic t_window();
        wr(10'h10F, 16'hFFFF);
        rd("R3 low window", 10'h001, 16'h000F);
        wr(10'h281, 16'hFFFF);
        rd("R3 high window", 10'h001, 16'h810F);
        wr(10'h103, 16'h0000);
        rd("R3 partial clear", 10'h001, 16'h810C);
        chk("R4 pin_out", pin_out, 16'h810C);
    endtask

    task automatic t_open_drain();
        wr(10'h101, 16'h0000);
        wr(10'h002, 16'h0001);
        chk("R4 od low drives", {pin_oe[0], pin_out[0]}, 2'b10);
        wr(10'h003, 16'h0001);
        chk("R4 od high floats", {pin_oe[0], pin_out[0]}, 2'b00);
    endtask

    task automatic t_din();
        @(negedge clk); pin_in = 16'hA5C3;
        wait_n(2);
        rd("R5 din", 10'h000, 16'hA5C3);
        pin_in = 16'hFFFF;
        wait_n(3);
        wr(10'h00A, 16'hFFFF);
        wait_n(1);
        rd("R6 no pend when high", 10'h00A, 16'h0);
    endtask

    task automatic t_low_level();
        wr(10'h004, 16'h0004);
        chk("R11 irq idle", {15'h0, irq}, 16'h0);
        pin_in[2] = 1'b0;
        wait_n(3);
        rd("R6 low pend", 10'h00A, 16'h0004);
        chk("R11 irq on", {15'h0, irq}, 16'h1);
        wr(10'h00A, 16'h0004);
        rd("R10 cleared", 10'h00A, 16'h0);
        wait_n(1);
        rd("R10 level reasserts", 10'h00A, 16'h0004);
    endtask

    task automatic t_high_level();
        pin_in[2] = 1'b1;
        wait_n(3);
        wr(10'h00A, 16'hFFFF);
        wait_n(1);
        rd("R6 clear after rise", 10'h00A, 16'h0);
        wr(10'h008, 16'h0004);
        wait_n(1);
        rd("R7 high pend", 10'h00A, 16'h0004);
        pin_in[2] = 1'b0;
        wait_n(3);
        wr(10'h00A, 16'h0004);
        wait_n(2);
        rd("R7 low not pend", 10'h00A, 16'h0);
        chk("R11 irq off", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_fall();
        wr(10'h006, 16'h0004);
        wr(10'h009, 16'h0004);
        pin_in[2] = 1'b1;
        wait_n(3);
        rd("R8 rise ignored", 10'h00A, 16'h0);
        pin_in[2] = 1'b0;
        wait_n(3);
        rd("R8 fall pend", 10'h00A, 16'h0004);
        wr(10'h00A, 16'h0004);
        wait_n(3);
        rd("R8 one shot", 10'h00A, 16'h0);
    endtask

    task automatic t_rise();
        wr(10'h008, 16'h0004);
        wait_n(1);
        rd("R9 no pend steady", 10'h00A, 16'h0);
        pin_in[2] = 1'b1;
        wait_n(3);
        rd("R9 rise pend", 10'h00A, 16'h0004);
        wr(10'h00A, 16'h0004);
        wait_n(3);
        rd("R9 one shot", 10'h00A, 16'h0);
        pin_in[2] = 1'b0;
        wait_n(3);
        rd("R9 fall ignored", 10'h00A, 16'h0);
    endtask

    task automatic t_irq_mask();
        pin_in[2] = 1'b1;
        wait_n(3);
        wr(10'h005, 16'h0004);
        rd("R11 pend kept", 10'h00A, 16'h0004);
        chk("R11 masked", {15'h0, irq}, 16'h0);
        wr(10'h004, 16'h0004);
        chk("R11 unmasked", {15'h0, irq}, 16'h1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_setclr();
        t_window();
        t_open_drain();
        t_din();
        t_low_level();
        t_high_level();
        t_fall();
        t_rise();
        t_irq_mask();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule